// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block tracks the coherence state of the single line held by a private write-back cache that sits on a shared snooping bus. It takes two kinds of command. From its own core it takes read and write. From the bus it observes read and read-with-invalidate requests issued by other caches. It holds the line in one of four states: Modified, Exclusive, Shared or Invalid. For each command it processes, it reports one action: write the line back, issue a bus read, issue a bus read-with-invalidate, or none.

A core miss starts a bus request and raises a busy flag. The fill state is decided only when the lower level's response strobe arrives. A read miss fills Shared if the wired shared line was high at the response, and Exclusive if it was low. A write miss or upgrade fills Modified. While busy, core commands are dropped. During a snooped read, the block drives its own share of the bus shared signal whenever it holds a valid copy.

Data storage, arbitration and the lower-level cache lie outside this block. A core command and a bus command never arrive in the same cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, the line state is Invalid (`line_state` = 0). `busy`, `act_valid` and `share_drive` are all 0. The state encoding is I=0, S=1, E=2, M=3. The action encoding is NONE=0, FLUSH=1, BUS_RD=2, BUS_RDX=3.
- R2: A core read in Invalid produces action BUS_RD in the cycle after the command. It also raises `busy`, and the state stays Invalid. A response that arrives with `share_in`=0 then makes the state Exclusive and clears `busy`.
- R3: The same read miss fills Shared if `share_in`=1 in the response cycle.
- R4: A core write in Invalid or in Shared produces action BUS_RDX and raises `busy`. The response then makes the state Modified, whatever the value of `share_in`.
- R5: In Exclusive, a core read keeps Exclusive and a core write moves to Modified. Both report action NONE and neither raises `busy`.
- R6: In Modified, a snooped read reports FLUSH and moves to Shared. A snooped read-with-invalidate reports FLUSH and moves to Invalid.
- R7: In Exclusive, a snooped read moves to Shared and a snooped read-with-invalidate moves to Invalid, both with action NONE. In Shared, a snooped read-with-invalidate moves to Invalid with NONE, and a snooped read keeps Shared with NONE.
- R8: In Invalid, a snooped command reports action NONE and leaves the state Invalid.
- R9: `share_drive` is 1 exactly while `snoop_rd` is high and the state is not Invalid. It is combinational and is 0 otherwise.
- R10: While `busy` is 1, core commands are dropped. They produce no `act_valid`, no state change and no new request.
- R11: A response strobe while not busy has no effect on the state or on `busy`.
- R12: In Modified, core reads and writes keep Modified with action NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_rd | input | 1 | Core read command |
| core_wr | input | 1 | Core write command |
| snoop_rd | input | 1 | Snooped bus read from another cache |
| snoop_rdx | input | 1 | Snooped bus read-with-invalidate from another cache |
| resp_valid | input | 1 | Lower-level response strobe completing an outstanding miss |
| share_in | input | 1 | Wired shared line from the other caches, sampled with the response |
| act_valid | output | 1 | One-cycle pulse: a command was processed |
| act_code | output | 2 | Action for the processed command (NONE/FLUSH/BUS_RD/BUS_RDX) |
| line_state | output | 2 | Current line state (I/S/E/M) |
| busy | output | 1 | A core miss is outstanding |
| share_drive | output | 1 | This cache's contribution to the bus shared line |

## Verification
Every state is reached through real miss sequences, and each of the four commands is then applied to it. This separates the hit paths, which act silently, from the miss paths, which issue a request and wait for the response. It also separates snoops that cost a write-back from those that do not. The read miss is repeated with the shared line high and with it low, which tells the Exclusive fill apart from the Shared fill. The write is issued from both Invalid and Shared, which proves the upgrade path. Core commands sent during an outstanding miss, and a response strobe with no miss pending, show that both are dropped.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;
  localparam int ST_W  = 2;
  localparam int ACT_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_NONE  = 2'd0,
    ACT_FLUSH = 2'd1,
    ACT_RD    = 2'd2,
    ACT_RDX   = 2'd3
  } line_act_e;

  typedef enum logic [2:0] {
    CMD_IDLE    = 3'd0,
    CMD_CORE_RD = 3'd1,
    CMD_CORE_WR = 3'd2,
    CMD_SNP_RD  = 3'd3,
    CMD_SNP_RDX = 3'd4
  } line_cmd_e;
endpackage

// File: rtl/mesi_cmd_select.sv
module mesi_cmd_select
  import mesi_line_pkg::*;
(
  input  logic      core_rd,
  input  logic      core_wr,
  input  logic      snoop_rd,
  input  logic      snoop_rdx,
  input  logic      busy,
  output line_cmd_e cmd
);
  always_comb begin
    cmd = CMD_IDLE;
    if (snoop_rdx)              cmd = CMD_SNP_RDX;
    else if (snoop_rd)          cmd = CMD_SNP_RD;
    else if (core_wr && !busy)  cmd = CMD_CORE_WR;
    else if (core_rd && !busy)  cmd = CMD_CORE_RD;
  end

  always_comb begin
    if (busy && (cmd == CMD_CORE_RD || cmd == CMD_CORE_WR))
      p_core_gated_r10: assert (1'b0);
  end
endmodule

// File: rtl/mesi_transition.sv
module mesi_transition
  import mesi_line_pkg::*;
(
  input  line_st_e  cur,
  input  line_cmd_e cmd,
  output line_st_e  nxt,
  output line_act_e act,
  output logic      act_en,
  output logic      miss_start,
  output logic      miss_is_wr
);
  always_comb begin
    nxt        = cur;
    act        = ACT_NONE;
    act_en     = (cmd != CMD_IDLE);
    miss_start = 1'b0;
    miss_is_wr = 1'b0;
    unique case (cmd)
      CMD_CORE_RD: begin
        if (cur == ST_I) begin
          act        = ACT_RD;
          miss_start = 1'b1;
        end
      end
      CMD_CORE_WR: begin
        if (cur == ST_I || cur == ST_S) begin
          act        = ACT_RDX;
          miss_start = 1'b1;
          miss_is_wr = 1'b1;
        end else begin
          nxt = ST_M;
        end
      end
      CMD_SNP_RD: begin
        if (cur == ST_M) act = ACT_FLUSH;
        if (cur == ST_M || cur == ST_E) nxt = ST_S;
      end
      CMD_SNP_RDX: begin
        if (cur == ST_M) act = ACT_FLUSH;
        nxt = ST_I;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (act == ACT_FLUSH)
      p_flush_from_m_r6: assert (cur == ST_M);
  end
endmodule

// File: rtl/mesi_miss_track.sv
module mesi_miss_track
  import mesi_line_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     miss_start,
  input  logic     miss_is_wr,
  input  logic     resp_valid,
  input  logic     share_in,
  output logic     busy,
  output logic     fill_en,
  output line_st_e fill_state
);
  logic busy_q, busy_d;
  logic wr_q, wr_d;
  logic wr_en;

  assign fill_en = busy_q && resp_valid;
  assign wr_en   = miss_start;

  always_comb begin
    busy_d = busy_q;
    if (fill_en)         busy_d = 1'b0;
    else if (miss_start) busy_d = 1'b1;
    wr_d = miss_is_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (wr_en) wr_q <= wr_d;
    end
  end

  always_comb begin
    if (wr_q)          fill_state = ST_M;
    else if (share_in) fill_state = ST_S;
    else               fill_state = ST_E;
  end

  assign busy = busy_q;

  p_resp_clears_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && resp_valid) |=> !busy_q);
  p_idle_resp_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && resp_valid && !miss_start) |=> !busy_q);
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_line_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_rd,
  input  logic             core_wr,
  input  logic             snoop_rd,
  input  logic             snoop_rdx,
  input  logic             resp_valid,
  input  logic             share_in,
  output logic             act_valid,
  output logic [ACT_W-1:0] act_code,
  output logic [ST_W-1:0]  line_state,
  output logic             busy,
  output logic             share_drive
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  line_cmd_e cmd;
  line_st_e  st_q, st_d, nxt, fill_state;
  line_act_e act, act_q;
  logic      act_en, act_v_q;
  logic      miss_start, miss_is_wr, fill_en;
  logic      st_en;

  mesi_cmd_select u_sel (
    .core_rd   (core_rd),
    .core_wr   (core_wr),
    .snoop_rd  (snoop_rd),
    .snoop_rdx (snoop_rdx),
    .busy      (busy),
    .cmd       (cmd)
  );

  mesi_transition u_tr (
    .cur        (st_q),
    .cmd        (cmd),
    .nxt        (nxt),
    .act        (act),
    .act_en     (act_en),
    .miss_start (miss_start),
    .miss_is_wr (miss_is_wr)
  );

  mesi_miss_track u_miss (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .miss_start (miss_start),
    .miss_is_wr (miss_is_wr),
    .resp_valid (resp_valid),
    .share_in   (share_in),
    .busy       (busy),
    .fill_en    (fill_en),
    .fill_state (fill_state)
  );

  // A fill from the lower level takes priority over a concurrent snoop.
  always_comb begin
    st_en = fill_en || act_en;
    st_d  = fill_en ? fill_state : nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q    <= ST_I;
      act_v_q <= 1'b0;
      act_q   <= ACT_NONE;
    end else begin
      act_v_q <= act_en;
      if (st_en)  st_q  <= st_d;
      if (act_en) act_q <= act;
    end
  end

  assign act_valid   = act_v_q;
  assign act_code    = act_q;
  assign line_state  = st_q;
  assign share_drive = snoop_rd && (st_q != ST_I);

  p_miss_issues_req_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> (act_valid && (act_code == ACT_RD || act_code == ACT_RDX)));
  p_busy_blocks_core_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && (core_rd || core_wr) && !snoop_rd && !snoop_rdx && !resp_valid)
      |=> ($stable(line_state) && !act_valid));
  p_e_only_by_fill_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_state == ST_E && $past(line_state) != ST_E) |-> $past(busy));
  p_m_entry_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_state == ST_M && $past(line_state) != ST_M) |-> ($past(core_wr) || $past(busy)));
  p_snoop_i_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (line_state == ST_I && (snoop_rd || snoop_rdx) && !resp_valid)
      |=> (line_state == ST_I && act_code == ACT_NONE));
endmodule

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic core_rd, core_wr, snoop_rd, snoop_rdx, resp_valid, share_in;
  logic act_valid, busy, share_drive;
  logic [1:0] act_code, line_state;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
  localparam logic [1:0] AN = 2'd0, AF = 2'd1, AR = 2'd2, AX = 2'd3;

  always #2.5 clk = ~clk;

  mesi_line_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .core_rd(core_rd), .core_wr(core_wr),
    .snoop_rd(snoop_rd), .snoop_rdx(snoop_rdx), .resp_valid(resp_valid),
    .share_in(share_in), .act_valid(act_valid), .act_code(act_code),
    .line_state(line_state), .busy(busy), .share_drive(share_drive)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Drive one cycle of inputs after the falling edge, sample just after the rising edge.
  task automatic apply(input logic rd, input logic wr, input logic srd, input logic srdx,
                       input logic rsp, input logic shin);
    @(negedge clk);
    core_rd = rd; core_wr = wr; snoop_rd = srd; snoop_rdx = srdx;
    resp_valid = rsp; share_in = shin;
    @(posedge clk);
    #1;
    core_rd = 0; core_wr = 0; snoop_rd = 0; snoop_rdx = 0; resp_valid = 0; share_in = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    core_rd = 0; core_wr = 0; snoop_rd = 0; snoop_rdx = 0; resp_valid = 0; share_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic fill_read(input logic shin);
    apply(1, 0, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 1, shin);
  endtask

  task automatic fill_write();
    apply(0, 1, 0, 0, 0, 0);
    apply(0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "state", line_state, SI);
    check("R1", "busy", busy, 0);
    check("R1", "act_valid", act_valid, 0);
    check("R1", "share_drive", share_drive, 0);
  endtask

  task automatic t_read_miss_excl();
    do_reset();
    apply(1, 0, 0, 0, 0, 0);
    check("R2", "act_valid", act_valid, 1);
    check("R2", "act_code", act_code, AR);
    check("R2", "busy", busy, 1);
    check("R2", "state during miss", line_state, SI);
    apply(0, 0, 0, 0, 1, 0);
    check("R2", "state after fill", line_state, SE);
    check("R2", "busy after fill", busy, 0);
  endtask

  task automatic t_read_miss_shared();
    do_reset();
    fill_read(1);
    check("R3", "state after shared fill", line_state, SS);
    check("R3", "busy", busy, 0);
  endtask

  task automatic t_write_miss();
    do_reset();
    apply(0, 1, 0, 0, 0, 0);
    check("R4", "act_code from I", act_code, AX);
    check("R4", "busy from I", busy, 1);
    apply(0, 0, 0, 0, 1, 1);
    check("R4", "state after wr fill", line_state, SM);
    do_reset();
    fill_read(1);
    apply(0, 1, 0, 0, 0, 0);
    check("R4", "act_code from S", act_code, AX);
    check("R4", "state while upgrading", line_state, SS);
    apply(0, 0, 0, 0, 1, 1);
    check("R4", "state after upgrade", line_state, SM);
  endtask

  task automatic t_excl_hits();
    do_reset();
    fill_read(0);
    apply(1, 0, 0, 0, 0, 0);
    check("R5", "rd hit act", act_code, AN);
    check("R5", "rd hit valid", act_valid, 1);
    check("R5", "rd hit state", line_state, SE);
    apply(0, 1, 0, 0, 0, 0);
    check("R5", "wr hit act", act_code, AN);
    check("R5", "wr hit state", line_state, SM);
    check("R5", "wr hit busy", busy, 0);
  endtask

  task automatic t_mod();
    do_reset();
    fill_write();
    apply(1, 0, 0, 0, 0, 0);
    check("R12", "M rd act", act_code, AN);
    check("R12", "M rd state", line_state, SM);
    apply(0, 1, 0, 0, 0, 0);
    check("R12", "M wr state", line_state, SM);
    check("R12", "M wr busy", busy, 0);
    apply(0, 0, 1, 0, 0, 0);
    check("R6", "M snoop rd act", act_code, AF);
    check("R6", "M snoop rd state", line_state, SS);
    do_reset();
    fill_write();
    apply(0, 0, 0, 1, 0, 0);
    check("R6", "M snoop rdx act", act_code, AF);
    check("R6", "M snoop rdx state", line_state, SI);
  endtask

  task automatic t_snoop_es();
    do_reset();
    fill_read(0);
    apply(0, 0, 1, 0, 0, 0);
    check("R7", "E snoop rd act", act_code, AN);
    check("R7", "E snoop rd state", line_state, SS);
    apply(0, 0, 1, 0, 0, 0);
    check("R7", "S snoop rd state", line_state, SS);
    apply(0, 0, 0, 1, 0, 0);
    check("R7", "S snoop rdx act", act_code, AN);
    check("R7", "S snoop rdx state", line_state, SI);
    do_reset();
    fill_read(0);
    apply(0, 0, 0, 1, 0, 0);
    check("R7", "E snoop rdx act", act_code, AN);
    check("R7", "E snoop rdx state", line_state, SI);
  endtask

  task automatic t_snoop_i();
    do_reset();
    apply(0, 0, 1, 0, 0, 0);
    check("R8", "I snoop rd act", act_code, AN);
    check("R8", "I snoop rd state", line_state, SI);
    apply(0, 0, 0, 1, 0, 0);
    check("R8", "I snoop rdx state", line_state, SI);
    check("R8", "I snoop busy", busy, 0);
  endtask

  task automatic t_share_drive();
    do_reset();
    @(negedge clk); snoop_rd = 1; #1;
    check("R9", "share_drive in I", share_drive, 0);
    @(negedge clk); snoop_rd = 0;
    fill_read(0);
    @(negedge clk); #1;
    check("R9", "share_drive idle E", share_drive, 0);
    snoop_rdx = 0; snoop_rd = 1; #1;
    check("R9", "share_drive snoop E", share_drive, 1);
    @(posedge clk); #1; snoop_rd = 0;
    @(negedge clk); snoop_rd = 1; #1;
    check("R9", "share_drive snoop S", share_drive, 1);
    @(posedge clk); #1; snoop_rd = 0;
  endtask

  task automatic t_busy_block();
    do_reset();
    apply(1, 0, 0, 0, 0, 0);
    apply(0, 1, 0, 0, 0, 0);
    check("R10", "blocked wr valid", act_valid, 0);
    check("R10", "blocked wr state", line_state, SI);
    check("R10", "still busy", busy, 1);
    apply(0, 0, 0, 0, 1, 0);
    check("R10", "fill kind kept as read", line_state, SE);
  endtask

  task automatic t_idle_resp();
    do_reset();
    apply(0, 0, 0, 0, 1, 1);
    check("R11", "state after stray resp", line_state, SI);
    check("R11", "busy after stray resp", busy, 0);
    fill_read(0);
    apply(0, 0, 0, 0, 1, 1);
    check("R11", "E kept after stray resp", line_state, SE);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_read_miss_excl();
        t_read_miss_shared();
        t_write_miss();
        t_excl_hits();
        t_mod();
        t_snoop_es();
        t_snoop_i();
        t_share_drive();
        t_busy_block();
        t_idle_resp();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule